// File: doc/BRIEF.md
# Threaded-Code Token Dispatch Engine

This block is a memory-mapped helper that takes over the inner-interpreter dispatch step of a token-threaded Forth running on a small 8-bit host. The host keeps its instruction pointer inside the block. One byte write to the control register starts the step. The block then fetches a 16-bit token over a byte-wide memory read port, moves the pointer past it, and expands the token into a 32-bit code address. The expansion is a left shift that fills the vacated low bits with zeros, followed by the addition of a dictionary base. The result is placed in a W vector register. The host reads the status bit until it drops, then jumps indirectly through W.

Storing tokens as 16 bits and scaling them in hardware keeps the threaded code compact. The code space can still be far larger than 64 KB, as long as every entry point lies on the chosen alignment. For example, a 4-bit shift reaches 1 MB with entry points on 16-byte boundaries. The host may rewrite the pointer between steps, so nesting and unnesting can be done in software.

Top module: `token_next_engine`

## Requirements
- R1: After reset, every register reads zero: the status bit, the three pointer bytes, the shift select, the three base bytes and the four W bytes.
- R2: A write of any data value to register 0x0 while idle starts one dispatch step. From the cycle after that write until the step completes, bit 0 of register 0x0 reads 1.
- R3: A step issues two byte reads. The first is at the pointer and the second at the pointer plus 1, modulo 2^24. The first byte is the token's low byte. mem_req stays high and mem_addr stays unchanged until mem_ack, and mem_rdata is taken in the cycle mem_ack is high.
- R4: The pointer, which is little endian at 0x4 (low), 0x5 and 0x6, increases by 2 at the end of every step. The carry propagates across all 24 bits, and the pointer wraps from 0xFFFFFE to 0x000000.
- R5: The shift select, bits [2:0] of register 0x1, chooses a left shift of 2×code bits for codes 0 to 4. Codes 5 to 7 act as a shift of 8.
- R6: W equals (token << shift) + base, computed in 32 bits with zeros above the result. The base is a 24-bit value, little endian at 0x8, 0x9 and 0xA. W is read little endian at 0xC to 0xF.
- R7: W keeps its previous value until a step completes. In particular, it does not change while the engine is busy.
- R8: A write to register 0x0 while busy is ignored and causes no extra memory reads.
- R9: Writes to the pointer, shift-select or base registers while busy are discarded.
- R10: W becomes valid and the busy bit clears on the clock edge that takes in the second byte. mem_req is low from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 4 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data for the address of the previous cycle |
| mem_req | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 24 | Memory byte address |
| mem_ack | input | 1 | One-cycle acknowledge that also qualifies mem_rdata |
| mem_rdata | input | 8 | Memory read data |

## Verification
A trigger write captured at clock edge E raises mem_req with the pointer address at E. Busy therefore reads 1 through the host port, whose read data arrives one edge after the address is presented. Each byte read ends at the edge where mem_ack is sampled high. At the edge that takes in the second byte, W, the advanced pointer and the busy bit all change, and mem_req falls. The bench drives inputs and samples outputs on falling edges, so every read is sampled one full cycle after its address is set. The memory model checks each request address against the scoreboard queue at the moment it acknowledges. On the falling edge after the second acknowledge, it checks that the request has already been withdrawn.

// File: rtl/tne_pkg.sv
package tne_pkg;
  typedef enum logic {ST_IDLE, ST_READ} fetch_st_t;

  // host register map (4-bit address)
  localparam logic [3:0] RA_CTRL  = 4'h0;
  localparam logic [3:0] RA_CFG   = 4'h1;
  localparam logic [3:0] RA_IP0   = 4'h4;
  localparam logic [3:0] RA_BASE0 = 4'h8;
  localparam logic [3:0] RA_W0    = 4'hC;
endpackage

// File: rtl/tne_host_regs.sv
module tne_host_regs
  import tne_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [3:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [VEC_W-1:0]  w_vec,
  output logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] base,
  output logic [CODE_W-1:0] code,
  output logic              trig
);
  localparam int IP_BYTES = ADDR_W / 8;
  localparam int W_BYTES  = VEC_W / 8;

  logic [7:0] rd_next;

  assign trig = host_we && !busy && (host_addr == RA_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ip   <= '0;
      base <= '0;
      code <= '0;
    end else if (done) begin
      ip <= ip + ADDR_W'(2);
    end else if (host_we && !busy) begin
      for (int b = 0; b < IP_BYTES; b++) begin
        if (host_addr == RA_IP0 + 4'(b))   ip[8*b +: 8]   <= host_wdata;
        if (host_addr == RA_BASE0 + 4'(b)) base[8*b +: 8] <= host_wdata;
      end
      if (host_addr == RA_CFG) code <= host_wdata[CODE_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (host_addr == RA_CTRL) rd_next = {7'b0, busy};
    if (host_addr == RA_CFG)  rd_next = 8'(code);
    for (int b = 0; b < IP_BYTES; b++) begin
      if (host_addr == RA_IP0 + 4'(b))   rd_next = ip[8*b +: 8];
      if (host_addr == RA_BASE0 + 4'(b)) rd_next = base[8*b +: 8];
    end
    for (int b = 0; b < W_BYTES; b++)
      if (host_addr == RA_W0 + 4'(b)) rd_next = w_vec[8*b +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_next;
  end

  // R4: pointer moves by exactly two per completed step
  a_r4_ip_advance: assert property (@(posedge clk) disable iff (rst)
    done |=> (ip == $past(ip) + ADDR_W'(2)));

  // R9: a busy engine keeps its pointer and configuration
  a_r9_busy_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> ($stable(ip) && $stable(base) && $stable(code)));
endmodule

// File: rtl/tne_fetch.sv
module tne_fetch
  import tne_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int TOK_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [ADDR_W-1:0] ip,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done,
  output logic [TOK_W-1:0]  token
);
  localparam int TOK_BYTES = TOK_W / 8;
  localparam int IDX_W     = (TOK_BYTES > 2) ? $clog2(TOK_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TOK_BYTES - 1);

  fetch_st_t        st;
  logic [IDX_W-1:0] idx;
  logic [TOK_W-1:0] part;

  assign busy  = (st != ST_IDLE);
  assign done  = (st == ST_READ) && mem_ack && (idx == LAST);
  assign token = {mem_rdata, part[TOK_W-9:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      idx      <= '0;
      part     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (trig) begin
          st       <= ST_READ;
          mem_req  <= 1'b1;
          mem_addr <= ip;
          idx      <= '0;
        end
        ST_READ: if (mem_ack) begin
          if (idx == LAST) begin
            st      <= ST_IDLE;
            mem_req <= 1'b0;
          end else begin
            part[8*idx +: 8] <= mem_rdata;
            idx              <= idx + 1'b1;
            mem_addr         <= mem_addr + ADDR_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: a trigger starts a request at the current pointer
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    trig |=> (busy && mem_req && mem_addr == $past(ip)));

  // R3: an unanswered request holds its address
  a_r3_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R10: last byte ends the step and withdraws the request
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy && !mem_req));
endmodule

// File: rtl/tne_scaler.sv
module tne_scaler #(
  parameter int TOK_W      = 16,
  parameter int VEC_W      = 32,
  parameter int ADDR_W     = 24,
  parameter int CODE_W     = 3,
  parameter int NUM_SHIFT  = 5,
  parameter int SHIFT_STEP = 2
) (
  input  logic [TOK_W-1:0]  token,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] base,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [CODE_W-1:0] TOP = CODE_W'(NUM_SHIFT - 1);

  logic [VEC_W-1:0] cand [NUM_SHIFT];
  logic [CODE_W-1:0] sel;

  // one pre-shifted candidate per supported shift amount
  for (genvar k = 0; k < NUM_SHIFT; k++) begin : g_cand
    assign cand[k] = VEC_W'(token) << (k * SHIFT_STEP);
  end

  always_comb begin
    sel = (code > TOP) ? TOP : code;
    vec = cand[sel] + VEC_W'(base);
  end
endmodule

// File: rtl/token_next_engine.sv
module token_next_engine #(
  parameter int ADDR_W     = 24,
  parameter int TOK_W      = 16,
  parameter int VEC_W      = 32,
  parameter int CODE_W     = 3,
  parameter int NUM_SHIFT  = 5,
  parameter int SHIFT_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [3:0]        host_addr,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [7:0]        mem_rdata
);
  logic              busy, done, trig;
  logic [ADDR_W-1:0] ip, base;
  logic [CODE_W-1:0] code;
  logic [TOK_W-1:0]  token;
  logic [VEC_W-1:0]  scaled, w_vec;

  tne_host_regs #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .CODE_W(CODE_W)) u_regs (
    .clk, .rst, .host_we, .host_addr, .host_wdata, .host_rdata,
    .busy, .done, .w_vec, .ip, .base, .code, .trig
  );

  tne_fetch #(.ADDR_W(ADDR_W), .TOK_W(TOK_W)) u_fetch (
    .clk, .rst, .trig, .ip, .mem_ack, .mem_rdata,
    .mem_req, .mem_addr, .busy, .done, .token
  );

  tne_scaler #(.TOK_W(TOK_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
               .NUM_SHIFT(NUM_SHIFT), .SHIFT_STEP(SHIFT_STEP)) u_scale (
    .token, .code, .base, .vec(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst)       w_vec <= '0;
    else if (done) w_vec <= scaled;
  end

  // R7: W only moves on a completed step
  a_r7_w_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(w_vec));
endmodule

// File: tb/tb_token_next_engine.sv
module tb_token_next_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = 4'h0;
  logic [7:0]  host_wdata = 8'h0;
  logic [7:0]  host_rdata;
  logic        mem_req;
  logic [23:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'h0;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  int wait_cnt = 0;
  int ack_cnt = 0;

  logic [23:0] exp_addr_q[$];
  logic [31:0] exp_w_q[$];

  logic [23:0] m_ip = '0;
  logic [23:0] m_base = '0;
  logic [2:0]  m_code = '0;
  logic [31:0] m_w = '0;

  token_next_engine dut (
    .clk, .rst, .host_we, .host_addr, .host_wdata, .host_rdata,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model and address monitor
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      if (ack_cnt % 2 == 0) check("R10 request low after last byte", 32'(mem_req), 32'd0);
    end else if (mem_req && !rst) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        ack_cnt++;
        mem_ack = 1'b1;
        mem_rdata = mb(mem_addr);
        if (exp_addr_q.size() == 0) check("R8 unexpected read", 32'(mem_addr), 32'hFFFFFFFF);
        else check("R3 read address", 32'(mem_addr), 32'(exp_addr_q.pop_front()));
      end else wait_cnt++;
    end else wait_cnt = 0;
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic rd_multi(input logic [3:0] a, input int n, output logic [31:0] v);
    logic [7:0] b;
    v = '0;
    for (int i = 0; i < n; i++) begin
      rd(a + 4'(i), b);
      v[8*i +: 8] = b;
    end
  endtask

  task automatic set_ip(input logic [23:0] v);
    for (int i = 0; i < 3; i++) wr(4'h4 + 4'(i), v[8*i +: 8]);
    m_ip = v;
  endtask

  task automatic set_base(input logic [23:0] v);
    for (int i = 0; i < 3; i++) wr(4'h8 + 4'(i), v[8*i +: 8]);
    m_base = v;
  endtask

  task automatic set_code(input logic [2:0] c);
    wr(4'h1, {5'b0, c});
    m_code = c;
  endtask

  // driver: predicts the step and pushes it to the scoreboard, then triggers
  task automatic drive_next(input logic [7:0] tval);
    logic [15:0] tok;
    int sh;
    tok = {mb(m_ip + 24'd1), mb(m_ip)};
    sh = (m_code > 3'd4) ? 8 : 2 * int'(m_code);
    exp_addr_q.push_back(m_ip);
    exp_addr_q.push_back(m_ip + 24'd1);
    exp_w_q.push_back((32'(tok) << sh) + 32'(m_base));
    m_ip = m_ip + 24'd2;
    wr(4'h0, tval);
  endtask

  // monitor: waits for completion and compares W and the pointer
  task automatic finish_next(input string req);
    logic [7:0] st;
    logic [31:0] v;
    int n = 0;
    st = 8'h1;
    while (st[0] && n < 200) begin rd(4'h0, st); n++; end
    check({req, " busy clears"}, 32'(st[0]), 32'd0);
    check("R10 request low when idle", 32'(mem_req), 32'd0);
    rd_multi(4'hC, 4, v);
    m_w = exp_w_q.pop_front();
    check({req, " W value"}, v, m_w);
    rd_multi(4'h4, 3, v);
    check("R4 pointer after step", v, 32'(m_ip));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [31:0] v;
    logic [31:0] prev_w;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(4'h0, b); check("R1 status", 32'(b), 0);
    rd(4'h1, b); check("R1 shift select", 32'(b), 0);
    rd_multi(4'h4, 3, v); check("R1 pointer", v, 0);
    rd_multi(4'h8, 3, v); check("R1 base", v, 0);
    rd_multi(4'hC, 4, v); check("R1 W", v, 0);

    // R3/R5 shift 0 then each shift code, including clamped codes
    set_ip(24'h000100);
    drive_next(8'h00); finish_next("R5 code0");
    for (int c = 1; c < 8; c++) begin
      set_code(3'(c));
      drive_next(8'(c)); finish_next("R5 code sweep");
    end

    // R6 base offset with code 2
    set_code(3'd2); set_base(24'h012340);
    drive_next(8'h77); finish_next("R6 base offset");
    set_code(3'd4); set_base(24'hFFFFFF);
    drive_next(8'h11); finish_next("R6 max base");

    // R4 carry across bytes and wrap at the top
    set_ip(24'h00FFFF); drive_next(8'h01); finish_next("R4 byte carry");
    set_ip(24'hFFFFFE); drive_next(8'h02); finish_next("R4 wrap");
    set_ip(24'hFFFFFF); drive_next(8'h03); finish_next("R3 second read wraps");

    // busy-window behaviour with a slow memory
    lat = 12;
    set_ip(24'h234560); set_code(3'd3); set_base(24'h000010);
    prev_w = m_w;
    drive_next(8'hFF);
    rd(4'h0, b); check("R2 busy while stepping", 32'(b[0]), 32'd1);
    rd_multi(4'hC, 4, v); check("R7 W holds while busy", v, prev_w);
    wr(4'h0, 8'h5A);            // R8 trigger while busy: no extra reads
    wr(4'h4, 8'h33);            // R9 pointer write while busy
    wr(4'h1, 8'h01);            // R9 config write while busy
    wr(4'h8, 8'hEE);            // R9 base write while busy
    finish_next("R9 busy writes discarded");
    rd(4'h1, b); check("R9 shift select unchanged", 32'(b), 32'd3);
    rd_multi(4'h8, 3, v); check("R9 base unchanged", v, 32'h000010);

    // back-to-back steps with an immediate memory
    lat = 0;
    for (int i = 0; i < 4; i++) begin
      drive_next(8'(i)); finish_next("R2 back to back");
    end
    check("R8 no leftover reads", 32'(exp_addr_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule